// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block holds the interrupt flags of a timer/counter that has several compare/capture channels. The counter core gives it one-cycle event pulses: overflow, retrigger, counter event, a match or capture per channel, two recoverable faults, two non-recoverable faults, a debug fault state, and a ramp-index change together with the lock-update control bit. Each pulse sets a sticky flag. Software reads the flags at one bus address and clears them by writing ones. The block also derives two flags of its own. A capture that arrives while its channel flag is still pending raises a shared error flag. A ramp-index change while updates are locked raises an update-fault flag.

A bus read of a channel's capture register clears that channel's flag, but only while the channel is in capture mode. All flags are ANDed with an enable vector of the same layout and ORed into one interrupt request. The counter, compare logic, fault detection, capture data and the enable register live outside the block.

Top module: `tmr_irq_flags`

## Requirements
- R1: After synchronous reset every flag is 0, and a read of the flag address (default 0x2C) returns 0.
- R2: Flags sit at these positions: overflow 0, retrigger 1, counter event 2, capture error 3, update fault 10, debug fault 11, recoverable faults A/B 12/13, non-recoverable faults 0/1 14/15, channel flags 16+n. Every other bit reads 0.
- R3: A write to the flag address clears each flag whose write-data bit is 1 and leaves the others unchanged. A write to any other address changes no flag.
- R4: The flag of channel n is set by a match pulse or a capture pulse on channel n.
- R5: A bus read of capture address CAP_BASE+4n (default 0x3C+4n) clears the flag of channel n when that channel's capture-mode input is 1, and leaves it set when that input is 0.
- R6: A capture pulse on a channel whose flag is already 1 sets the error flag (bit 3).
- R7: A ramp-index change pulse sets the update-fault flag (bit 10) only while lock-update is 1.
- R8: Overflow, retrigger, counter-event, debug-fault and the four fault pulses each set their flag on the following clock edge.
- R9: When a hardware set and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R10: When a capture-register read and a new capture hit the same channel in the same cycle, the channel flag ends up set and the error flag is not raised.
- R11: The interrupt request is 1 exactly when some flag is 1 and its enable bit (same bit position) is 1.
- R12: A read returns data in the same cycle that the read enable is high. Reads of any address other than the flag address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (ones clear flags) |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, zero wait states |
| evt_ovf | input | 1 | Overflow pulse |
| evt_trg | input | 1 | Retrigger pulse |
| evt_cnt | input | 1 | Counter event pulse |
| evt_dfs | input | 1 | Debug fault state pulse |
| evt_flt_rec | input | 2 | Recoverable fault A/B pulses |
| evt_flt_nrec | input | 2 | Non-recoverable fault 0/1 pulses |
| evt_ramp_chg | input | 1 | Ramp index change pulse |
| lock_upd | input | 1 | Lock-update control level |
| evt_match | input | NUM_CH | Per-channel compare match pulses |
| evt_capture | input | NUM_CH | Per-channel capture pulses |
| cap_mode | input | NUM_CH | Channel is in capture mode |
| irq_en | input | 32 | Interrupt enable vector, same layout as flags |
| irq_req | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: four channels, an 8-bit address, the flag register at 0x2C and capture registers from 0x3C. With these values all four channel flags are present, and every fixed flag position can be set in one burst, which covers the whole valid mask and the zero reserved bits. The capture addresses are distinct, so the bench can read a capture register while its channel is in capture mode and while it is not. It can also line up same-cycle collisions of set against write-one-clear and of capture against capture-read.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    localparam int REG_W  = 32;

    // Flag positions inside the register
    localparam int B_OVF  = 0;
    localparam int B_TRG  = 1;
    localparam int B_CNT  = 2;
    localparam int B_ERR  = 3;
    localparam int B_UFS  = 10;
    localparam int B_DFS  = 11;
    localparam int B_RFLT = 12;   // recoverable faults, two bits
    localparam int B_NFLT = 14;   // non-recoverable faults, two bits
    localparam int B_MC   = 16;   // first channel flag

    localparam int N_RFLT = 2;
    localparam int N_NFLT = 2;
    localparam int MAX_CH = REG_W - B_MC;

    // Events that do not depend on the channel count
    typedef struct packed {
        logic                ovf;
        logic                trg;
        logic                cnt;
        logic                dfs;
        logic [N_RFLT-1:0]   rflt;
        logic [N_NFLT-1:0]   nflt;
        logic                ramp_chg;
        logic                lock;
    } core_evt_t;

    function automatic logic [REG_W-1:0] valid_mask(input int nch);
        logic [REG_W-1:0] m;
        m = '0;
        m[B_OVF] = 1'b1;
        m[B_TRG] = 1'b1;
        m[B_CNT] = 1'b1;
        m[B_ERR] = 1'b1;
        m[B_UFS] = 1'b1;
        m[B_DFS] = 1'b1;
        for (int i = 0; i < N_RFLT; i++) m[B_RFLT+i] = 1'b1;
        for (int i = 0; i < N_NFLT; i++) m[B_NFLT+i] = 1'b1;
        for (int i = 0; i < MAX_CH; i++) if (i < nch) m[B_MC+i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/tmr_irq_bus_port.sv
module tmr_irq_bus_port
    import tmr_irq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_CH    = 4,
    parameter int FLAG_ADDR = 'h2C,
    parameter int CAP_BASE  = 'h3C
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    input  logic [NUM_CH-1:0] cap_mode,
    input  logic [REG_W-1:0]  flags,
    output logic [REG_W-1:0]  w1c_mask,
    output logic [NUM_CH-1:0] cap_rd_clr,
    output logic [REG_W-1:0]  bus_rdata
);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

    logic hit_flag;
    assign hit_flag = (bus_addr == FLAG_A);

    assign w1c_mask  = (bus_wr && hit_flag) ? bus_wdata : '0;
    assign bus_rdata = (bus_rd && hit_flag) ? flags : '0;

    // One capture-register decoder per channel, 4-byte stride
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cap_dec
        localparam logic [ADDR_W-1:0] CH_A = ADDR_W'(CAP_BASE + 4*g);
        assign cap_rd_clr[g] = bus_rd && (bus_addr == CH_A) && cap_mode[g];
    end

endmodule

// File: rtl/tmr_irq_set_logic.sv
module tmr_irq_set_logic
    import tmr_irq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  core_evt_t         evt,
    input  logic [NUM_CH-1:0] evt_match,
    input  logic [NUM_CH-1:0] evt_capture,
    input  logic [NUM_CH-1:0] cap_rd_clr,
    input  logic [NUM_CH-1:0] mc_pend,
    output logic [REG_W-1:0]  set_mask
);
    // A capture is lost only if its flag stays pending through this cycle;
    // a capture-register read in the same cycle frees the slot.
    logic [NUM_CH-1:0] overrun;
    assign overrun = evt_capture & mc_pend & ~cap_rd_clr;

    always_comb begin
        set_mask        = '0;
        set_mask[B_OVF] = evt.ovf;
        set_mask[B_TRG] = evt.trg;
        set_mask[B_CNT] = evt.cnt;
        set_mask[B_ERR] = |overrun;
        set_mask[B_UFS] = evt.ramp_chg & evt.lock;
        set_mask[B_DFS] = evt.dfs;
        for (int i = 0; i < N_RFLT; i++) set_mask[B_RFLT+i] = evt.rflt[i];
        for (int i = 0; i < N_NFLT; i++) set_mask[B_NFLT+i] = evt.nflt[i];
        for (int c = 0; c < NUM_CH; c++)
            set_mask[B_MC+c] = evt_match[c] | evt_capture[c];
    end

endmodule

// File: rtl/tmr_irq_flag_reg.sv
module tmr_irq_flag_reg
    import tmr_irq_pkg::*;
#(
    parameter logic [REG_W-1:0] VALID = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_mask,
    input  logic [REG_W-1:0] clr_mask,
    output logic [REG_W-1:0] flags_q
);
    // Set has priority over clear so no event is dropped
    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= ((flags_q & ~clr_mask) | set_mask) & VALID;
    end

endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tmr_irq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_CH    = 4,     // at most MAX_CH
    parameter int FLAG_ADDR = 'h2C,
    parameter int CAP_BASE  = 'h3C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic              evt_ovf,
    input  logic              evt_trg,
    input  logic              evt_cnt,
    input  logic              evt_dfs,
    input  logic [1:0]        evt_flt_rec,
    input  logic [1:0]        evt_flt_nrec,
    input  logic              evt_ramp_chg,
    input  logic              lock_upd,
    input  logic [NUM_CH-1:0] evt_match,
    input  logic [NUM_CH-1:0] evt_capture,
    input  logic [NUM_CH-1:0] cap_mode,
    input  logic [31:0]       irq_en,
    output logic              irq_req
);
    localparam logic [REG_W-1:0] VALID = valid_mask(NUM_CH);

    core_evt_t         evt;
    logic [REG_W-1:0]  flags_q;
    logic [REG_W-1:0]  w1c_mask;
    logic [REG_W-1:0]  set_mask;
    logic [REG_W-1:0]  clr_mask;
    logic [NUM_CH-1:0] cap_rd_clr;

    always_comb begin
        evt.ovf      = evt_ovf;
        evt.trg      = evt_trg;
        evt.cnt      = evt_cnt;
        evt.dfs      = evt_dfs;
        evt.rflt     = evt_flt_rec;
        evt.nflt     = evt_flt_nrec;
        evt.ramp_chg = evt_ramp_chg;
        evt.lock     = lock_upd;
    end

    tmr_irq_bus_port #(
        .ADDR_W(ADDR_W), .NUM_CH(NUM_CH),
        .FLAG_ADDR(FLAG_ADDR), .CAP_BASE(CAP_BASE)
    ) u_bus (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .cap_mode  (cap_mode),
        .flags     (flags_q),
        .w1c_mask  (w1c_mask),
        .cap_rd_clr(cap_rd_clr),
        .bus_rdata (bus_rdata)
    );

    tmr_irq_set_logic #(.NUM_CH(NUM_CH)) u_set (
        .evt        (evt),
        .evt_match  (evt_match),
        .evt_capture(evt_capture),
        .cap_rd_clr (cap_rd_clr),
        .mc_pend    (flags_q[B_MC +: NUM_CH]),
        .set_mask   (set_mask)
    );

    assign clr_mask = w1c_mask | (REG_W'(cap_rd_clr) << B_MC);

    tmr_irq_flag_reg #(.VALID(VALID)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .set_mask(set_mask),
        .clr_mask(clr_mask),
        .flags_q (flags_q)
    );

    assign irq_req = |(flags_q & irq_en);

endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk
    import tmr_irq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_CH    = 4,
    parameter int FLAG_ADDR = 'h2C,
    parameter int CAP_BASE  = 'h3C
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rd,
    input logic              evt_ovf,
    input logic              evt_ramp_chg,
    input logic              lock_upd,
    input logic [NUM_CH-1:0] evt_match,
    input logic [NUM_CH-1:0] evt_capture,
    input logic [NUM_CH-1:0] cap_mode,
    input logic              irq_req,
    input logic [31:0]       flags_q
);
    localparam logic [ADDR_W-1:0] FA  = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] CA0 = ADDR_W'(CAP_BASE);
    localparam logic [31:0]       VM  = valid_mask(NUM_CH);

    logic rd_cc0;
    assign rd_cc0 = bus_rd && (bus_addr == CA0) && cap_mode[0];

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (flags_q == '0));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (flags_q & ~VM) == '0);

    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == FA && bus_wdata[B_OVF] && !evt_ovf) |=> !flags_q[B_OVF]);

    assert_w0_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (flags_q[B_OVF] && !(bus_wr && bus_addr == FA && bus_wdata[B_OVF])) |=> flags_q[B_OVF]);

    assert_match_sets_R4: assert property (@(posedge clk) disable iff (rst)
        evt_match[0] |=> flags_q[B_MC]);

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_cc0 && !evt_capture[0] && !evt_match[0]) |=> !flags_q[B_MC]);

    assert_overrun_err_R6: assert property (@(posedge clk) disable iff (rst)
        (evt_capture[0] && flags_q[B_MC] && !rd_cc0) |=> flags_q[B_ERR]);

    assert_locked_update_R7: assert property (@(posedge clk) disable iff (rst)
        (evt_ramp_chg && lock_upd) |=> flags_q[B_UFS]);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        evt_ovf |=> flags_q[B_OVF]);

    assert_idle_no_irq_R11: assert property (@(posedge clk) disable iff (rst)
        (flags_q == '0) |-> !irq_req);

endmodule

bind tmr_irq_flags tmr_irq_flags_chk #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .FLAG_ADDR(FLAG_ADDR), .CAP_BASE(CAP_BASE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rd      (bus_rd),
    .evt_ovf     (evt_ovf),
    .evt_ramp_chg(evt_ramp_chg),
    .lock_upd    (lock_upd),
    .evt_match   (evt_match),
    .evt_capture (evt_capture),
    .cap_mode    (cap_mode),
    .irq_req     (irq_req),
    .flags_q     (flags_q)
);

// File: tb/tmr_irq_flags_tb.sv
`timescale 1ns/1ps
module tmr_irq_flags_tb;
    localparam int ADDR_W = 8;
    localparam int NCH    = 4;
    localparam logic [7:0] FA = 8'h2C;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic              evt_ovf = 0, evt_trg = 0, evt_cnt = 0, evt_dfs = 0;
    logic [1:0]        evt_flt_rec = '0, evt_flt_nrec = '0;
    logic              evt_ramp_chg = 0, lock_upd = 0;
    logic [NCH-1:0]    evt_match = '0, evt_capture = '0, cap_mode = '0;
    logic [31:0]       irq_en = '1;
    logic              irq_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    tmr_irq_flags u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .evt_ovf(evt_ovf), .evt_trg(evt_trg), .evt_cnt(evt_cnt), .evt_dfs(evt_dfs),
        .evt_flt_rec(evt_flt_rec), .evt_flt_nrec(evt_flt_nrec),
        .evt_ramp_chg(evt_ramp_chg), .lock_upd(lock_upd),
        .evt_match(evt_match), .evt_capture(evt_capture), .cap_mode(cap_mode),
        .irq_en(irq_en), .irq_req(irq_req)
    );

    typedef struct {
        logic [31:0] rdata;
        logic        irq;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    // Monitor: compares each read cycle against the oldest expected item
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_rd && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (bus_rdata !== e.rdata || irq_req !== e.irq) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             e.tag, bus_rdata, irq_req, e.rdata, e.irq);
                end
            end
        end
    end

    task automatic clear_pulses();
        evt_ovf = 0; evt_trg = 0; evt_cnt = 0; evt_dfs = 0;
        evt_flt_rec = '0; evt_flt_nrec = '0; evt_ramp_chg = 0;
        evt_match = '0; evt_capture = '0;
        bus_wr = 0; bus_rd = 0; bus_wdata = '0; bus_addr = '0;
    endtask

    // Caller sets signals after begin_cyc; end_cyc lets one edge apply them
    task automatic begin_cyc(); @(negedge clk); endtask
    task automatic end_cyc();   @(negedge clk); clear_pulses(); endtask

    task automatic rd_at(input logic [7:0] a, input logic [31:0] exp,
                         input logic ei, input string tag);
        exp_t e;
        begin_cyc();
        bus_rd = 1; bus_addr = a;
        e.rdata = exp; e.irq = ei; e.tag = tag;
        sb_q.push_back(e);
        end_cyc();
    endtask

    task automatic rd_flags(input logic [31:0] exp, input logic ei, input string tag);
        rd_at(FA, exp, ei, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        begin_cyc();
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        end_cyc();
    endtask

    initial begin
        #(5.0 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd_flags(32'h0, 1'b0, "R1 reset");

        // R8 overflow sets, R11 request with enable
        begin_cyc(); evt_ovf = 1; end_cyc();
        rd_flags(32'h1, 1'b1, "R8 overflow flag");
        irq_en = '0;
        rd_flags(32'h1, 1'b0, "R11 masked request");
        irq_en = '1;

        // R3 write-zero and foreign address do nothing; write-one clears
        wr(FA, 32'h0);
        rd_flags(32'h1, 1'b1, "R3 write zero");
        wr(8'h30, 32'hFFFF_FFFF);
        rd_flags(32'h1, 1'b1, "R3 other address");
        wr(FA, 32'h1);
        rd_flags(32'h0, 1'b0, "R3 write one");

        // R8/R2 remaining single-bit events
        begin_cyc();
        evt_trg = 1; evt_cnt = 1; evt_dfs = 1; evt_flt_rec = 2'b11; evt_flt_nrec = 2'b11;
        end_cyc();
        rd_flags(32'h0000_F806, 1'b1, "R8 trg cnt dfs faults");
        wr(FA, 32'h0000_4000);
        rd_flags(32'h0000_B806, 1'b1, "R3 clear one fault");
        wr(FA, 32'hFFFF_FFFF);
        rd_flags(32'h0, 1'b0, "R3 clear all");

        // R7 update fault
        begin_cyc(); evt_ramp_chg = 1; end_cyc();
        rd_flags(32'h0, 1'b0, "R7 unlocked ramp change");
        lock_upd = 1;
        begin_cyc(); evt_ramp_chg = 1; end_cyc();
        rd_flags(32'h0000_0400, 1'b1, "R7 locked ramp change");
        lock_upd = 0;
        wr(FA, 32'hFFFF_FFFF);

        // R4 match and capture set channel flags
        begin_cyc(); evt_match = 4'b0100; end_cyc();
        rd_flags(32'h0004_0000, 1'b1, "R4 match ch2");
        begin_cyc(); evt_capture = 4'b0010; end_cyc();
        rd_flags(32'h0006_0000, 1'b1, "R4 capture ch1");
        wr(FA, 32'hFFFF_FFFF);

        // R6 overrun, R5 capture read clears, R12 non-flag read returns 0
        cap_mode = 4'b0111;
        begin_cyc(); evt_capture = 4'b0001; end_cyc();
        rd_flags(32'h0001_0000, 1'b1, "R4 capture ch0");
        begin_cyc(); evt_capture = 4'b0001; end_cyc();
        rd_flags(32'h0001_0008, 1'b1, "R6 overrun");
        wr(FA, 32'h8);
        rd_flags(32'h0001_0000, 1'b1, "R3 clear error");
        rd_at(8'h3C, 32'h0, 1'b1, "R12 capture address read");
        rd_flags(32'h0, 1'b0, "R5 capture read clears ch0");

        // R5 compare-mode channel keeps its flag on read
        begin_cyc(); evt_capture = 4'b1000; end_cyc();
        rd_at(8'h48, 32'h0, 1'b1, "R12 ch3 address read");
        rd_flags(32'h0008_0000, 1'b1, "R5 compare mode no clear");
        wr(FA, 32'hFFFF_FFFF);

        // R9 set beats write-one clear
        begin_cyc(); evt_ovf = 1; bus_wr = 1; bus_addr = FA; bus_wdata = 32'h1; end_cyc();
        rd_flags(32'h1, 1'b1, "R9 set wins");
        wr(FA, 32'hFFFF_FFFF);

        // R10 capture and capture-read collide
        begin_cyc(); evt_capture = 4'b0010; end_cyc();
        begin_cyc(); evt_capture = 4'b0010; bus_rd = 1; bus_addr = 8'h40; end_cyc();
        rd_flags(32'h0002_0000, 1'b1, "R10 collision keeps flag no error");
        wr(FA, 32'hFFFF_FFFF);

        // R2 every flag at once; reserved bits stay 0
        lock_upd = 1;
        begin_cyc(); evt_match = 4'b1111; end_cyc();
        begin_cyc();
        evt_ovf = 1; evt_trg = 1; evt_cnt = 1; evt_dfs = 1; evt_flt_rec = 2'b11;
        evt_flt_nrec = 2'b11; evt_ramp_chg = 1; evt_capture = 4'b1111;
        end_cyc();
        lock_upd = 0;
        rd_flags(32'h000F_FC0F, 1'b1, "R2 full map");

        // R11 single enable follows its flag
        irq_en = 32'h0000_0400;
        rd_flags(32'h000F_FC0F, 1'b1, "R11 enable ufs");
        wr(FA, 32'h0000_0400);
        rd_flags(32'h000F_F80F, 1'b0, "R11 ufs cleared");
        irq_en = 32'hFFF0_03F0;
        rd_flags(32'h000F_F80F, 1'b0, "R11 reserved enables only");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R12: %0d reads unanswered, expected 0", sb_q.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule